// File: doc/BRIEF.md
# Instruction Length and Skip Unit

This unit sits between instruction fetch and execute in a small 16-bit processor. Each fetched instruction word is split into a 4-bit opcode and two 6-bit operand fields. The unit also works out how many words the instruction occupies, from one to three. An operand selector in the range 0x10–0x17, or equal to 0x1E or 0x1F, pulls one extra word from the instruction stream. An opcode of zero marks a non-basic instruction. For such an instruction the first operand field carries an extended opcode, and only the second operand field can add a word.

When a conditional instruction fails its test, execute pulses a failed-test input. The unit then remembers that the next instruction must be skipped. It consumes that instruction without passing it on for execution and moves the program counter past all of its words, including trailing operand words. Only one instruction is ever skipped per failed test.

For a normal instruction the next-PC output points just past the instruction word itself. Execute reads the operand words from there. The unit also flags the one defined extended opcode, the subroutine call (code 0x01), and flags every other extended code as illegal for one cycle.

Top module: `instr_len_skip_unit`

## Requirements
- R1: One cycle after `instr_valid` is high, `out_valid` is high and `opcode`, `op_a` and `op_b` equal bits [3:0], [9:4] and [15:10] of the accepted word. `out_valid` is low in any cycle that does not follow an accepted word.
- R2: `instr_len` is 1, plus 1 when `op_b` is in 0x10–0x17 or is 0x1E or 0x1F.
- R3: `op_a` in that same set adds a further 1 to `instr_len` only when the opcode is not 0. For opcode 0, `nonbasic` is 1 and `op_a` has no effect on the length.
- R4: For an instruction that is not skipped, `skipped` is 0 and `next_pc` is `pc_in` + 1, modulo 2^16.
- R5: For a skipped instruction, `skipped` is 1 and `next_pc` is `pc_in` + `instr_len`, modulo 2^16. A wrap past 0xFFFF is allowed.
- R6: A `cond_fail` pulse arms a skip. The skip stays armed across idle cycles and is applied to the next accepted instruction only. The instruction after that one is not skipped, even when the skipped instruction was itself a conditional.
- R7: A non-basic instruction that is not skipped and whose extended code (`op_a`) is not 0x01 sets `illegal` high for exactly one cycle, together with `out_valid`.
- R8: A non-basic instruction that is not skipped and has extended code 0x01 sets `jsr` high. A skipped instruction never sets `jsr` or `illegal`.
- R9: While `rst_n` is low, and in the first cycle after reset is released, `out_valid`, `skipped`, `jsr`, `illegal` and `next_pc` are all 0, and no skip is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word and PC are presented this cycle |
| instr_word | input | 16 | Fetched instruction word |
| pc_in | input | 16 | Address of `instr_word` |
| cond_fail | input | 1 | Pulse from execute: a conditional test failed |
| out_valid | output | 1 | Decoded results are valid this cycle |
| opcode | output | 4 | Basic opcode field |
| op_a | output | 6 | First operand field (extended opcode when non-basic) |
| op_b | output | 6 | Second operand field |
| instr_len | output | 2 | Instruction length in words, 1 to 3 |
| next_pc | output | 16 | PC after the instruction word, or after the whole instruction when skipped |
| skipped | output | 1 | The instruction was skipped and must not execute |
| nonbasic | output | 1 | Opcode is zero |
| jsr | output | 1 | Non-basic subroutine call, not skipped |
| illegal | output | 1 | Reserved extended opcode, not skipped |

## Verification
The most dangerous wrong state is a stale or missing skip-armed bit. It shows on the very next accepted instruction: `skipped` is wrong, and `next_pc` moves by the instruction length when it should move by one, or the reverse. A bit left set after a skip shows one instruction later, when a second instruction is wrongly skipped. A wrong length decode shows only through `instr_len`, and through `next_pc` when that instruction is skipped. For this reason the stimulus skips instructions of each length and places the operand selectors at the edges of the word-adding set.

// File: rtl/ilsu_pkg.sv
package ilsu_pkg;

    localparam int OPC_W  = 4;
    localparam int OPD_W  = 6;
    localparam int WORD_W = OPC_W + 2 * OPD_W;
    localparam int LEN_W  = 2;

    localparam logic [OPD_W-1:0] IDX_LO     = 6'h10;
    localparam logic [OPD_W-1:0] IDX_HI     = 6'h17;
    localparam logic [OPD_W-1:0] IND_WORD   = 6'h1E;
    localparam logic [OPD_W-1:0] LIT_WORD   = 6'h1F;
    localparam logic [OPD_W-1:0] EXT_CALL   = 6'h01;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [OPD_W-1:0] fa;
        logic [OPD_W-1:0] fb;
        logic             nb;
    } fields_t;

    // An operand selector that consumes one trailing word of the stream.
    function automatic logic takes_word(input logic [OPD_W-1:0] sel);
        return ((sel >= IDX_LO) && (sel <= IDX_HI)) ||
               (sel == IND_WORD) || (sel == LIT_WORD);
    endfunction

endpackage

// File: rtl/ilsu_field_split.sv
module ilsu_field_split
    import ilsu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fields_t           flds
);
    localparam int A_LSB = OPC_W;
    localparam int B_LSB = OPC_W + OPD_W;

    always_comb begin
        flds.opc = word[A_LSB-1:0];
        flds.fa  = word[B_LSB-1:A_LSB];
        flds.fb  = word[WORD_W-1:B_LSB];
        flds.nb  = (word[A_LSB-1:0] == '0);
    end
endmodule

// File: rtl/ilsu_len_calc.sv
module ilsu_len_calc
    import ilsu_pkg::*;
#(
    parameter int NUM_OPD = 2
)(
    input  fields_t          flds,
    output logic [LEN_W-1:0] len
);
    logic [NUM_OPD-1:0] extra;
    logic [OPD_W-1:0]   sel [NUM_OPD];

    assign sel[0] = flds.fb;
    assign sel[NUM_OPD-1] = flds.fa;

    // Operand 0 (b) always counts; later operands count only for basic opcodes.
    for (genvar i = 0; i < NUM_OPD; i++) begin : g_opd
        if (i == 0) begin : g_always
            assign extra[i] = takes_word(sel[i]);
        end else begin : g_basic_only
            assign extra[i] = takes_word(sel[i]) && !flds.nb;
        end
    end

    always_comb begin
        len = LEN_W'(1);
        for (int k = 0; k < NUM_OPD; k++) begin
            len = len + LEN_W'(extra[k]);
        end
    end
endmodule

// File: rtl/ilsu_skip_ctrl.sv
module ilsu_skip_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_fail,
    input  logic instr_valid,
    output logic skip_now
);
    typedef struct packed {
        logic pending;
    } skip_st_t;

    skip_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (instr_valid && st_q.pending) begin
            st_d.pending = 1'b0;          // exactly one instruction consumed
        end else if (cond_fail) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign skip_now = st_q.pending;

    // R6: an armed skip is used up by the instruction it is applied to.
    p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && st_q.pending) |=> !st_q.pending);

    // R6: a failed test with no instruction arriving leaves a skip armed.
    p_pend_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fail && !instr_valid) |=> st_q.pending);
endmodule

// File: rtl/instr_len_skip_unit.sv
module instr_len_skip_unit
    import ilsu_pkg::*;
#(
    parameter int PC_W = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr_word,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              cond_fail,
    output logic              out_valid,
    output logic [3:0]        opcode,
    output logic [5:0]        op_a,
    output logic [5:0]        op_b,
    output logic [1:0]        instr_len,
    output logic [PC_W-1:0]   next_pc,
    output logic              skipped,
    output logic              nonbasic,
    output logic              jsr,
    output logic              illegal
);
    typedef struct packed {
        logic              vld;
        fields_t           flds;
        logic [LEN_W-1:0]  len;
        logic [PC_W-1:0]   npc;
        logic              skp;
        logic              call;
        logic              ill;
    } out_st_t;

    fields_t          flds_w;
    logic [LEN_W-1:0] len_w;
    logic             skip_w;
    out_st_t          st_d, st_q;

    ilsu_field_split u_split (
        .word (instr_word),
        .flds (flds_w)
    );

    ilsu_len_calc #(.NUM_OPD(2)) u_len (
        .flds (flds_w),
        .len  (len_w)
    );

    ilsu_skip_ctrl u_skip (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_fail   (cond_fail),
        .instr_valid (instr_valid),
        .skip_now    (skip_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = instr_valid;
        st_d.skp  = 1'b0;
        st_d.call = 1'b0;
        st_d.ill  = 1'b0;
        if (instr_valid) begin
            st_d.flds = flds_w;
            st_d.len  = len_w;
            st_d.skp  = skip_w;
            if (skip_w) begin
                st_d.npc = pc_in + PC_W'(len_w);
            end else begin
                st_d.npc  = pc_in + PC_W'(1);
                st_d.call = flds_w.nb && (flds_w.fa == EXT_CALL);
                st_d.ill  = flds_w.nb && (flds_w.fa != EXT_CALL);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign opcode    = st_q.flds.opc;
    assign op_a      = st_q.flds.fa;
    assign op_b      = st_q.flds.fb;
    assign nonbasic  = st_q.flds.nb;
    assign instr_len = st_q.len;
    assign next_pc   = st_q.npc;
    assign skipped   = st_q.skp;
    assign jsr       = st_q.call;
    assign illegal   = st_q.ill;

    // R1: results appear only in the cycle after an accepted word.
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(instr_valid));

    // R2: a valid length is never zero.
    p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (instr_len != 2'd0));

    // R3: non-basic instructions can hold at most one trailing word.
    p_nb_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && nonbasic) |-> (instr_len <= 2'd2));

    // R4: an executed instruction advances the PC by one word.
    p_exec_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !skipped) |-> (next_pc == $past(pc_in) + PC_W'(1)));

    // R5: a skipped instruction advances the PC by its whole length.
    p_skip_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && skipped) |-> (next_pc == $past(pc_in) + PC_W'(instr_len)));

    // R7: illegal is reported only with a valid non-basic result.
    p_illegal_ctx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (out_valid && nonbasic));

    // R8: skipped instructions raise neither the call nor the illegal flag.
    p_skip_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        skipped |-> (!jsr && !illegal));

    // R9: with no result, all pulse flags are low.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!skipped && !illegal && !jsr));
endmodule

// File: tb/instr_len_skip_unit_bench.sv
module instr_len_skip_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic [15:0] pc_in = '0;
    logic        cond_fail = 1'b0;
    logic        out_valid, skipped, nonbasic, jsr, illegal;
    logic [3:0]  opcode;
    logic [5:0]  op_a, op_b;
    logic [1:0]  instr_len;
    logic [15:0] next_pc;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    instr_len_skip_unit u_instr_len_skip_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .pc_in(pc_in), .cond_fail(cond_fail),
        .out_valid(out_valid), .opcode(opcode), .op_a(op_a), .op_b(op_b),
        .instr_len(instr_len), .next_pc(next_pc), .skipped(skipped),
        .nonbasic(nonbasic), .jsr(jsr), .illegal(illegal)
    );

    // {b, a, op, expected length, expected call flag, expected illegal flag}
    localparam int NV = 11;
    localparam logic [19:0] VEC [NV] = '{
        {6'h01, 6'h00, 4'h1, 2'd1, 1'b0, 1'b0},
        {6'h10, 6'h00, 4'h2, 2'd2, 1'b0, 1'b0},
        {6'h1F, 6'h1E, 4'h3, 2'd3, 1'b0, 1'b0},
        {6'h17, 6'h17, 4'hF, 2'd3, 1'b0, 1'b0},
        {6'h18, 6'h1D, 4'h4, 2'd1, 1'b0, 1'b0},
        {6'h0F, 6'h10, 4'h5, 2'd2, 1'b0, 1'b0},
        {6'h20, 6'h3F, 4'hC, 2'd1, 1'b0, 1'b0},
        {6'h05, 6'h1F, 4'h0, 2'd1, 1'b0, 1'b1},
        {6'h1F, 6'h01, 4'h0, 2'd2, 1'b1, 1'b0},
        {6'h1E, 6'h10, 4'h0, 2'd2, 1'b0, 1'b1},
        {6'h1D, 6'h1B, 4'h9, 2'd1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one word for one cycle; results are read at the following negedge.
    task automatic issue(input logic [15:0] w, input logic [15:0] pc);
        @(negedge clk);
        instr_word  = w;
        pc_in       = pc;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic fail_pulse();
        @(negedge clk);
        cond_fail = 1'b1;
        @(negedge clk);
        cond_fail = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9", "out_valid in reset", 32'(out_valid), 0);
        chk("R9", "next_pc in reset", 32'(next_pc), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "flags after reset", 32'({out_valid, skipped, jsr, illegal}), 0);

        // R1 R2 R3 R4 R7 R8: table of unskipped instructions
        for (int i = 0; i < NV; i++) begin
            logic [15:0] w;
            logic [15:0] pc;
            w  = VEC[i][19:4];
            pc = 16'h0040 + 16'(i * 4);
            issue(w, pc);
            chk("R1", "out_valid", 32'(out_valid), 1);
            chk("R1", "opcode", 32'(opcode), 32'(w[3:0]));
            chk("R1", "op_a", 32'(op_a), 32'(w[9:4]));
            chk("R1", "op_b", 32'(op_b), 32'(w[15:10]));
            chk("R2", "instr_len", 32'(instr_len), 32'(VEC[i][3:2]));
            chk("R3", "nonbasic", 32'(nonbasic), 32'(w[3:0] == 4'h0));
            chk("R4", "next_pc", 32'(next_pc), 32'(pc + 16'd1));
            chk("R4", "skipped", 32'(skipped), 0);
            chk("R8", "jsr", 32'(jsr), 32'(VEC[i][1]));
            chk("R7", "illegal", 32'(illegal), 32'(VEC[i][0]));
        end

        // R7: illegal lasts one cycle only, R1: out_valid drops when idle
        issue({6'h05, 6'h1F, 4'h0}, 16'h0300);
        chk("R7", "illegal pulse", 32'(illegal), 1);
        @(negedge clk);
        chk("R7", "illegal after one cycle", 32'(illegal), 0);
        chk("R1", "out_valid idle", 32'(out_valid), 0);

        // R5: skip a three-word instruction
        fail_pulse();
        issue({6'h1F, 6'h1E, 4'h3}, 16'h0100);
        chk("R5", "skipped len3", 32'(skipped), 1);
        chk("R5", "next_pc len3", 32'(next_pc), 32'h0103);
        chk("R5", "instr_len len3", 32'(instr_len), 3);
        issue({6'h01, 6'h00, 4'h1}, 16'h0103);
        chk("R6", "after skip not skipped", 32'(skipped), 0);
        chk("R6", "after skip next_pc", 32'(next_pc), 32'h0104);

        // R6: skipped conditional does not chain
        fail_pulse();
        issue({6'h01, 6'h00, 4'hC}, 16'h0200);
        chk("R6", "conditional skipped", 32'(skipped), 1);
        chk("R5", "next_pc len1 skip", 32'(next_pc), 32'h0201);
        issue({6'h10, 6'h01, 4'hD}, 16'h0201);
        chk("R6", "no chained skip", 32'(skipped), 0);
        chk("R6", "no chained next_pc", 32'(next_pc), 32'h0202);

        // R6: armed skip survives idle cycles
        fail_pulse();
        repeat (3) @(negedge clk);
        chk("R6", "idle while armed", 32'(out_valid), 0);
        issue({6'h10, 6'h00, 4'h2}, 16'h0400);
        chk("R6", "skip after idle", 32'(skipped), 1);
        chk("R5", "next_pc len2 skip", 32'(next_pc), 32'h0402);

        // R8: skipped reserved code raises no illegal; R3 a ignored in skip length
        fail_pulse();
        issue({6'h05, 6'h1F, 4'h0}, 16'h0500);
        chk("R8", "skipped reserved no illegal", 32'(illegal), 0);
        chk("R3", "skipped nonbasic next_pc", 32'(next_pc), 32'h0501);

        // R8: skipped call raises no jsr
        fail_pulse();
        issue({6'h1F, 6'h01, 4'h0}, 16'h0600);
        chk("R8", "skipped call no jsr", 32'(jsr), 0);
        chk("R5", "skipped call next_pc", 32'(next_pc), 32'h0602);

        // R5: wrap past the top of the address space
        fail_pulse();
        issue({6'h17, 6'h11, 4'h2}, 16'hFFFE);
        chk("R5", "wrap next_pc", 32'(next_pc), 32'h0001);

        // R9: reset clears an armed skip
        fail_pulse();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        issue({6'h10, 6'h00, 4'h2}, 16'h0700);
        chk("R9", "skip cleared by reset", 32'(skipped), 0);
        chk("R9", "next_pc after reset", 32'(next_pc), 32'h0701);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule